// File: doc/BRIEF.md
# Dual-Operand MAC Accumulator Datapath

This block is the arithmetic core of a 16x16 multiply-accumulate unit. It holds a 40-bit accumulator and four 32-bit operand registers. Each operation takes two 32-bit source words. Operand A comes either from a general-register input or from operand register 0 or 1. Operand B comes either from a second general-register input or from operand register 2 or 3. From each word the block takes the upper or lower halfword and extends it. The 32-bit product then either replaces the accumulator or is added to it or subtracted from it.

The accumulator is presented as a 32-bit low word and an 8-bit guard byte. The guard byte is the top of a 40-bit two's-complement value. A special-register port lets control logic read and write both accumulator words and all four operand registers. A load-update port places a word fetched elsewhere into any operand register. That write lands at the same clock edge as the multiply, after the multiply has already read the old register contents.

Top module: `mac_acc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator low word, the guard byte and all four operand registers to zero.
- R2: The high-half select takes bits 31:16 of a source word and the low-half select takes bits 15:0. The unsigned multiply (op code 0) zero-extends the halfword. The other three op codes sign-extend it.
- R3: With `a_use_reg` high, operand A reads operand register 0 (`a_reg_sel`=0) or 1 (`a_reg_sel`=1). With `b_use_reg` high, operand B reads operand register 2 (`b_reg_sel`=0) or 3 (`b_reg_sel`=1). Otherwise the operands come from `gpr_a` and `gpr_b`.
- R4: The signed multiply (op code 1) loads the 32-bit product into the low word and fills every guard bit with product bit 31.
- R5: The unsigned multiply (op code 0) loads the 32-bit product into the low word and clears the guard byte.
- R6: Multiply-add (op code 2) sign-extends the product and adds it to the 40-bit value {guard, low}. The result is kept modulo 2^40, so 0x7F_FFFFFFFF + 1 becomes 0x80_00000000.
- R7: Multiply-subtract (op code 3) subtracts the sign-extended product from the 40-bit accumulator modulo 2^40.
- R8: The accumulator changes only at an edge where `op_valid` is high or a special-register write targets it. Otherwise it holds its value.
- R9: A special-register write to address 1 stores bits 7:0 of the written data in the guard byte. A read of address 1 returns the guard byte sign-extended to 32 bits.
- R10: The special-register addresses are: 0 for the accumulator low word, 1 for the guard byte, and 4, 5, 6 and 7 for operand registers 0 to 3. A read of address 2 or 3 returns zero. A write to address 2 or 3 changes nothing.
- R11: When `ld_valid` is high, `ld_data` is written into the operand register selected by `ld_idx`. In the same cycle the multiply uses the value that register held before the edge.
- R12: When `op_valid` and a special-register write to the accumulator occur in the same cycle, the multiply result wins. When a load-update and a special-register write target the same operand register, the loaded word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Perform the operation in op_code this cycle |
| op_code | input | 2 | 0 unsigned multiply, 1 signed multiply, 2 multiply-add, 3 multiply-subtract |
| a_use_reg | input | 1 | Operand A from an operand register instead of gpr_a |
| a_reg_sel | input | 1 | Operand A register: 0 selects register 0, 1 selects register 1 |
| a_take_hi | input | 1 | Operand A uses bits 31:16 (1) or bits 15:0 (0) |
| b_use_reg | input | 1 | Operand B from an operand register instead of gpr_b |
| b_reg_sel | input | 1 | Operand B register: 0 selects register 2, 1 selects register 3 |
| b_take_hi | input | 1 | Operand B uses bits 31:16 (1) or bits 15:0 (0) |
| gpr_a | input | 32 | General-register source word for operand A |
| gpr_b | input | 32 | General-register source word for operand B |
| ld_valid | input | 1 | Load-update strobe |
| ld_idx | input | 2 | Operand register that receives ld_data |
| ld_data | input | 32 | Loaded word |
| sr_we | input | 1 | Special-register write strobe |
| sr_waddr | input | 3 | Special-register write address |
| sr_wdata | input | 32 | Special-register write data |
| sr_raddr | input | 3 | Special-register read address |
| sr_rdata | output | 32 | Special-register read data, combinational |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 8 | Accumulator bits 39:32 (guard byte) |

## Verification
The bound checker checks several properties on every clock edge:
- the guard byte of a signed multiply equals the sign of the new low word;
- an unsigned multiply always clears the guard byte;
- the accumulator holds when neither an operation nor an accumulator write occurs;
- special-register writes to either accumulator word land exactly;
- a load-update always lands in the register it names;
- reset zeroes all state.

Only the bench's scenarios can show the following:
- that the halfword extraction and extension are right;
- that the 40-bit wrap works in both directions;
- that operand-register routing is correct;
- that a same-cycle load-update does not disturb the product it feeds.

The bench shows these by comparing against an independent arithmetic model over directed corners and seeded random traffic.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int GUARD_W = 8;
  localparam int ACC_W   = WORD_W + GUARD_W;
  localparam int NOPND   = 4;
  localparam int OIDX_W  = $clog2(NOPND);
  localparam int SRA_W   = OIDX_W + 1;

  typedef enum logic [1:0] {
    OP_UMUL = 2'd0,
    OP_MUL  = 2'd1,
    OP_MULA = 2'd2,
    OP_MULS = 2'd3
  } mac_op_e;

  localparam logic [SRA_W-1:0] SR_ACC_LO = SRA_W'(0);
  localparam logic [SRA_W-1:0] SR_ACC_HI = SRA_W'(1);

  // Pick one halfword of a source word and widen it to a full word.
  function automatic logic [WORD_W-1:0] half_ext(
    input logic [WORD_W-1:0] w,
    input logic              take_hi,
    input logic              zext
  );
    logic [HALF_W-1:0] h;
    h = take_hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    return zext ? {{HALF_W{1'b0}}, h} : {{HALF_W{h[HALF_W-1]}}, h};
  endfunction

  // Low word of the product; identical for signed and unsigned extended inputs.
  function automatic logic [WORD_W-1:0] mul_lo(
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b
  );
    logic [WORD_W-1:0] r;
    r = a * b;
    return r;
  endfunction

  // Next accumulator value for one operation.
  function automatic logic [ACC_W-1:0] acc_step(
    input mac_op_e           op,
    input logic [ACC_W-1:0]  acc,
    input logic [WORD_W-1:0] prod
  );
    logic [ACC_W-1:0] p_ext;
    logic [ACC_W-1:0] r;
    p_ext = {{GUARD_W{prod[WORD_W-1]}}, prod};
    unique case (op)
      OP_UMUL: r = {{GUARD_W{1'b0}}, prod};
      OP_MUL:  r = p_ext;
      OP_MULA: r = acc + p_ext;
      default: r = acc - p_ext;
    endcase
    return r;
  endfunction

  // Guard byte widened to a full word for the read port.
  function automatic logic [WORD_W-1:0] guard_sext(input logic [GUARD_W-1:0] g);
    return {{(WORD_W-GUARD_W){g[GUARD_W-1]}}, g};
  endfunction
endpackage

// File: rtl/mac_opnd_file.sv
module mac_opnd_file
  import mac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_en,
  input  logic [OIDX_W-1:0]       ld_idx,
  input  logic [WORD_W-1:0]       ld_data,
  input  logic                    sr_en,
  input  logic [OIDX_W-1:0]       sr_idx,
  input  logic [WORD_W-1:0]       sr_data,
  output logic [NOPND*WORD_W-1:0] regs_flat
);
  for (genvar i = 0; i < NOPND; i++) begin : g_reg
    logic [WORD_W-1:0] q;
    logic              hit_ld;
    logic              hit_sr;
    assign hit_ld = ld_en && (ld_idx == OIDX_W'(i));
    assign hit_sr = sr_en && (sr_idx == OIDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (hit_ld) q <= ld_data;   // load-update outranks the register write
      else if (hit_sr) q <= sr_data;
    end
    assign regs_flat[i*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/mac_opnd_sel.sv
module mac_opnd_sel
  import mac_pkg::*;
(
  input  logic [WORD_W-1:0]       gpr_word,
  input  logic [NOPND*WORD_W-1:0] regs_flat,
  input  logic                    use_reg,
  input  logic [OIDX_W-1:0]       reg_idx,
  input  logic                    take_hi,
  input  logic                    zext,
  output logic [WORD_W-1:0]       opnd
);
  logic [WORD_W-1:0] src;
  assign src  = use_reg ? regs_flat[reg_idx*WORD_W +: WORD_W] : gpr_word;
  assign opnd = half_ext(src, take_hi, zext);
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
  import mac_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  mac_op_e            op,
  input  logic [WORD_W-1:0]  prod,
  input  logic               sr_lo_we,
  input  logic               sr_hi_we,
  input  logic [WORD_W-1:0]  sr_lo_data,
  input  logic [GUARD_W-1:0] sr_hi_data,
  output logic [WORD_W-1:0]  acc_lo,
  output logic [GUARD_W-1:0] acc_hi
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (fire) begin
      acc_d = acc_step(op, acc_q, prod);
    end else begin
      if (sr_lo_we) acc_d[WORD_W-1:0]     = sr_lo_data;
      if (sr_hi_we) acc_d[ACC_W-1:WORD_W] = sr_hi_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc_lo = acc_q[WORD_W-1:0];
  assign acc_hi = acc_q[ACC_W-1:WORD_W];
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [1:0]           op_code,
  input  logic                 a_use_reg,
  input  logic                 a_reg_sel,
  input  logic                 a_take_hi,
  input  logic                 b_use_reg,
  input  logic                 b_reg_sel,
  input  logic                 b_take_hi,
  input  logic [WORD_W-1:0]    gpr_a,
  input  logic [WORD_W-1:0]    gpr_b,
  input  logic                 ld_valid,
  input  logic [OIDX_W-1:0]    ld_idx,
  input  logic [WORD_W-1:0]    ld_data,
  input  logic                 sr_we,
  input  logic [SRA_W-1:0]     sr_waddr,
  input  logic [WORD_W-1:0]    sr_wdata,
  input  logic [SRA_W-1:0]     sr_raddr,
  output logic [WORD_W-1:0]    sr_rdata,
  output logic [WORD_W-1:0]    acc_lo,
  output logic [GUARD_W-1:0]   acc_hi
);
  mac_op_e                 op_e;
  logic                    zext;
  logic [WORD_W-1:0]       opnd_a;
  logic [WORD_W-1:0]       opnd_b;
  logic [WORD_W-1:0]       prod;
  logic [NOPND*WORD_W-1:0] opnd_flat;

  // Named decode events, also observed by the checker.
  logic acc_sr_lo_we;
  logic acc_sr_hi_we;
  logic opnd_sr_we;

  assign op_e = mac_op_e'(op_code);
  assign zext = (op_e == OP_UMUL);

  assign acc_sr_lo_we = sr_we && (sr_waddr == SR_ACC_LO);
  assign acc_sr_hi_we = sr_we && (sr_waddr == SR_ACC_HI);
  assign opnd_sr_we   = sr_we && sr_waddr[SRA_W-1];

  mac_opnd_file u_regs (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_valid),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .sr_en     (opnd_sr_we),
    .sr_idx    (sr_waddr[OIDX_W-1:0]),
    .sr_data   (sr_wdata),
    .regs_flat (opnd_flat)
  );

  mac_opnd_sel u_sel_a (
    .gpr_word  (gpr_a),
    .regs_flat (opnd_flat),
    .use_reg   (a_use_reg),
    .reg_idx   ({1'b0, a_reg_sel}),
    .take_hi   (a_take_hi),
    .zext      (zext),
    .opnd      (opnd_a)
  );

  mac_opnd_sel u_sel_b (
    .gpr_word  (gpr_b),
    .regs_flat (opnd_flat),
    .use_reg   (b_use_reg),
    .reg_idx   ({1'b1, b_reg_sel}),
    .take_hi   (b_take_hi),
    .zext      (zext),
    .opnd      (opnd_b)
  );

  assign prod = mul_lo(opnd_a, opnd_b);

  mac_acc_reg u_acc (
    .clk        (clk),
    .rst        (rst),
    .fire       (op_valid),
    .op         (op_e),
    .prod       (prod),
    .sr_lo_we   (acc_sr_lo_we),
    .sr_hi_we   (acc_sr_hi_we),
    .sr_lo_data (sr_wdata),
    .sr_hi_data (sr_wdata[GUARD_W-1:0]),
    .acc_lo     (acc_lo),
    .acc_hi     (acc_hi)
  );

  always_comb begin
    sr_rdata = '0;
    if (sr_raddr == SR_ACC_LO)      sr_rdata = acc_lo;
    else if (sr_raddr == SR_ACC_HI) sr_rdata = guard_sext(acc_hi);
    else if (sr_raddr[SRA_W-1])     sr_rdata = opnd_flat[sr_raddr[OIDX_W-1:0]*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk
  import mac_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    op_valid,
  input logic [1:0]              op_code,
  input logic                    acc_sr_lo_we,
  input logic                    acc_sr_hi_we,
  input logic [WORD_W-1:0]       sr_wdata,
  input logic                    ld_valid,
  input logic [OIDX_W-1:0]       ld_idx,
  input logic [WORD_W-1:0]       ld_data,
  input logic [WORD_W-1:0]       acc_lo,
  input logic [GUARD_W-1:0]      acc_hi,
  input logic [NOPND*WORD_W-1:0] opnd_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_lo == '0 && acc_hi == '0 && opnd_flat == '0));

  // R4
  mul_guard_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd1) |=> (acc_hi == {GUARD_W{acc_lo[WORD_W-1]}}));

  // R5
  umul_guard_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd0) |=> (acc_hi == '0));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !acc_sr_lo_we && !acc_sr_hi_we) |=> ($stable(acc_lo) && $stable(acc_hi)));

  // R9
  guard_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_sr_hi_we && !op_valid) |=> (acc_hi == $past(sr_wdata[GUARD_W-1:0])));

  // R10
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_sr_lo_we && !op_valid) |=> (acc_lo == $past(sr_wdata)));

  // R11
  load_update_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (opnd_flat[$past(ld_idx)*WORD_W +: WORD_W] == $past(ld_data)));
endmodule

bind mac_acc_unit mac_acc_unit_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .acc_sr_lo_we (acc_sr_lo_we),
  .acc_sr_hi_we (acc_sr_hi_we),
  .sr_wdata     (sr_wdata),
  .ld_valid     (ld_valid),
  .ld_idx       (ld_idx),
  .ld_data      (ld_data),
  .acc_lo       (acc_lo),
  .acc_hi       (acc_hi),
  .opnd_flat    (opnd_flat)
);

// File: tb/tb_mac_acc_unit.sv
module tb_mac_acc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_code;
  logic        a_use_reg, a_reg_sel, a_take_hi;
  logic        b_use_reg, b_reg_sel, b_take_hi;
  logic [31:0] gpr_a, gpr_b;
  logic        ld_valid;
  logic [1:0]  ld_idx;
  logic [31:0] ld_data;
  logic        sr_we;
  logic [2:0]  sr_waddr;
  logic [31:0] sr_wdata;
  logic [2:0]  sr_raddr;
  logic [31:0] sr_rdata;
  logic [31:0] acc_lo;
  logic [7:0]  acc_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_acc_unit dut (.*);

  int checks = 0;
  int failures = 0;
  logic [39:0] m_acc;
  logic [31:0] m_opnd [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Halfword extraction restated with integer arithmetic.
  function automatic longint f_ext(input logic [31:0] w, input bit hi, input bit uns);
    int unsigned u;
    u = hi ? (w >> 16) : (w & 32'hFFFF);
    if (!uns && u >= 32768) return longint'(u) - 65536;
    return longint'(u);
  endfunction

  function automatic logic [39:0] f_acc(input logic [1:0] op, input logic [39:0] acc,
                                        input longint a, input longint b);
    longint p;
    logic [63:0] pv;
    logic [31:0] p32;
    longint s;
    logic [63:0] sv;
    p = a * b;
    pv = p;
    p32 = pv[31:0];
    case (op)
      2'd0: return {8'h00, p32};
      2'd1: return {{8{p32[31]}}, p32};
      2'd2: s = longint'($signed(acc)) + longint'($signed(p32));
      default: s = longint'($signed(acc)) - longint'($signed(p32));
    endcase
    sv = s;
    return sv[39:0];
  endfunction

  function automatic logic [31:0] f_rd(input logic [2:0] addr);
    if (addr == 3'd0) return m_acc[31:0];
    if (addr == 3'd1) return {{24{m_acc[39]}}, m_acc[39:32]};
    if (addr[2]) return m_opnd[addr[1:0]];
    return 32'h0;
  endfunction

  task automatic idle_inputs();
    op_valid = 0; op_code = 0;
    a_use_reg = 0; a_reg_sel = 0; a_take_hi = 0;
    b_use_reg = 0; b_reg_sel = 0; b_take_hi = 0;
    ld_valid = 0; ld_idx = 0; ld_data = 0;
    sr_we = 0; sr_waddr = 0; sr_wdata = 0;
  endtask

  // Computes the expected state from the current inputs, clocks once, checks.
  task automatic run(input string req);
    logic [39:0] nacc;
    logic [31:0] nop [4];
    logic [31:0] wa, wb;
    bit uns;
    nacc = m_acc;
    nop = m_opnd;
    wa = a_use_reg ? m_opnd[{1'b0, a_reg_sel}] : gpr_a;
    wb = b_use_reg ? m_opnd[{1'b1, b_reg_sel}] : gpr_b;
    uns = (op_code == 2'd0);
    if (sr_we) begin
      if (sr_waddr == 3'd0) nacc[31:0] = sr_wdata;
      else if (sr_waddr == 3'd1) nacc[39:32] = sr_wdata[7:0];
      else if (sr_waddr[2]) nop[sr_waddr[1:0]] = sr_wdata;
    end
    if (op_valid)
      nacc = f_acc(op_code, m_acc, f_ext(wa, a_take_hi, uns), f_ext(wb, b_take_hi, uns));
    if (ld_valid) nop[ld_idx] = ld_data;
    @(posedge clk);
    @(negedge clk);
    m_acc = nacc;
    m_opnd = nop;
    chk({req, " acc_lo"}, acc_lo, m_acc[31:0]);
    chk({req, " acc_hi"}, {24'h0, acc_hi}, {24'h0, m_acc[39:32]});
    idle_inputs();
  endtask

  task automatic rd(input string req, input logic [2:0] addr);
    sr_raddr = addr;
    #1;
    chk(req, sr_rdata, f_rd(addr));
  endtask

  task automatic sr_write(input logic [2:0] addr, input logic [31:0] data, input string req);
    sr_we = 1; sr_waddr = addr; sr_wdata = data;
    run(req);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_acc = '0;
    for (int i = 0; i < 4; i++) m_opnd[i] = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle_inputs();
    gpr_a = 0; gpr_b = 0; sr_raddr = 0;
    do_reset();

    // R1: dirty the state, reset again, expect all zero
    sr_write(3'd0, 32'hCAFE_F00D, "R10 setup");
    sr_write(3'd1, 32'h0000_0055, "R9 setup");
    sr_write(3'd5, 32'h1234_5678, "R10 setup");
    do_reset();
    chk("R1 acc_lo", acc_lo, 32'h0);
    chk("R1 acc_hi", {24'h0, acc_hi}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      sr_raddr = 3'(a);
      #1;
      chk("R1 read", sr_rdata, 32'h0);
    end

    // R9: guard write keeps 8 bits, read sign-extends
    sr_write(3'd1, 32'h0000_0080, "R9 neg");
    rd("R9 read neg", 3'd1);
    chk("R9 literal", sr_rdata, 32'hFFFF_FF80);
    sr_write(3'd1, 32'hABCD_0123, "R9 trunc");
    chk("R9 trunc literal", {24'h0, acc_hi}, 32'h23);

    // R10: operand register map and unmapped addresses
    sr_write(3'd4, 32'h0000_0004, "R10 reg0");
    sr_write(3'd5, 32'h0002_0000, "R10 reg1");
    sr_write(3'd6, 32'h7777_0000, "R10 reg2");
    sr_write(3'd7, 32'h0006_0000, "R10 reg3");
    sr_write(3'd3, 32'hFFFF_FFFF, "R10 unmapped write");
    for (int a = 0; a < 8; a++) rd("R10 map read", 3'(a));

    // R5: unsigned 0xFFFF * 0xFFFF
    op_valid = 1; op_code = 2'd0; gpr_a = 32'hFFFF_1234; a_take_hi = 1;
    gpr_b = 32'h0000_FFFF; b_take_hi = 0;
    run("R5 umul");
    chk("R5 literal", acc_lo, 32'hFFFE_0001);

    // R4: signed -32768 * 32767
    op_valid = 1; op_code = 2'd1; gpr_a = 32'h0000_8000; gpr_b = 32'h7FFF_0000; b_take_hi = 1;
    run("R4 mul");
    chk("R4 literal lo", acc_lo, 32'hC000_8000);
    chk("R4 literal hi", {24'h0, acc_hi}, 32'hFF);

    // R2: same word, signed versus unsigned extension
    op_valid = 1; op_code = 2'd1; gpr_a = 32'hFFFE_0003; a_take_hi = 1; gpr_b = 32'h0000_0005;
    run("R2 signed hi");
    chk("R2 signed literal", acc_lo, 32'hFFFF_FFF6);
    op_valid = 1; op_code = 2'd0; gpr_a = 32'hFFFE_0003; a_take_hi = 1; gpr_b = 32'h0000_0005;
    run("R2 unsigned hi");
    chk("R2 unsigned literal", acc_lo, 32'h0004_FFF6);
    op_valid = 1; op_code = 2'd1; gpr_a = 32'hFFFE_0003; a_take_hi = 0; gpr_b = 32'h0000_0005;
    run("R2 signed lo");
    chk("R2 lo literal", acc_lo, 32'h0000_000F);

    // R3: operands from registers 0 and 3
    op_valid = 1; op_code = 2'd1; a_use_reg = 1; a_reg_sel = 0; a_take_hi = 0;
    b_use_reg = 1; b_reg_sel = 1; b_take_hi = 1; gpr_a = 32'h0009_0009; gpr_b = 32'h0009_0009;
    run("R3 regs");
    chk("R3 literal", acc_lo, 32'h0000_0018);

    // R8: idle cycle with moving sources holds the accumulator
    gpr_a = 32'h1111_2222; gpr_b = 32'h3333_4444;
    run("R8 hold");
    chk("R8 literal", acc_lo, 32'h0000_0018);

    // R6: 40-bit wrap upward
    sr_write(3'd0, 32'hFFFF_FFFF, "R6 setup");
    sr_write(3'd1, 32'h0000_007F, "R6 setup");
    op_valid = 1; op_code = 2'd2; gpr_a = 32'h0000_0001; gpr_b = 32'h0000_0001;
    run("R6 mula");
    chk("R6 literal lo", acc_lo, 32'h0);
    chk("R6 literal hi", {24'h0, acc_hi}, 32'h80);
    rd("R6 read hi", 3'd1);

    // R7: 40-bit wrap downward
    op_valid = 1; op_code = 2'd3; gpr_a = 32'h0000_0001; gpr_b = 32'h0000_0001;
    run("R7 muls");
    chk("R7 literal lo", acc_lo, 32'hFFFF_FFFF);
    chk("R7 literal hi", {24'h0, acc_hi}, 32'h7F);

    // R11: load into register 1 while it feeds the multiply
    op_valid = 1; op_code = 2'd1; a_use_reg = 1; a_reg_sel = 1; a_take_hi = 1;
    gpr_b = 32'h0000_0003; ld_valid = 1; ld_idx = 2'd1; ld_data = 32'h0009_0000;
    run("R11 old value");
    chk("R11 literal", acc_lo, 32'h0000_0006);
    rd("R11 loaded", 3'd5);
    chk("R11 loaded literal", sr_rdata, 32'h0009_0000);

    // R12: operation beats accumulator write; load beats register write
    op_valid = 1; op_code = 2'd0; gpr_a = 32'h0000_0002; gpr_b = 32'h0000_0003;
    sr_we = 1; sr_waddr = 3'd0; sr_wdata = 32'h0000_DEAD;
    run("R12 op wins");
    chk("R12 op literal", acc_lo, 32'h0000_0006);
    ld_valid = 1; ld_idx = 2'd2; ld_data = 32'hAAAA_5555;
    sr_we = 1; sr_waddr = 3'd6; sr_wdata = 32'h1111_1111;
    run("R12 load wins");
    rd("R12 load read", 3'd6);
    chk("R12 load literal", sr_rdata, 32'hAAAA_5555);

    // Random traffic covering R2 R3 R6 R7 R10 R11 R12
    for (int n = 0; n < 400; n++) begin
      op_valid  = ($urandom % 10) < 7;
      op_code   = 2'($urandom);
      a_use_reg = 1'($urandom); a_reg_sel = 1'($urandom); a_take_hi = 1'($urandom);
      b_use_reg = 1'($urandom); b_reg_sel = 1'($urandom); b_take_hi = 1'($urandom);
      gpr_a = $urandom; gpr_b = $urandom;
      ld_valid = ($urandom % 10) < 3; ld_idx = 2'($urandom); ld_data = $urandom;
      sr_we = ($urandom % 10) < 2; sr_waddr = 3'($urandom); sr_wdata = $urandom;
      run("R6 random");
      rd("R10 random read", 3'($urandom));
    end

    finish_run();
  end
endmodule